// File: doc/BRIEF.md
# Serial Audio Transmit Clock and Frame Generator

This block drives the transmit side of a two-wire-plus-frame serial audio link in controller mode. It derives a bit clock and a left/right frame clock from its own clock and shifts out interleaved PCM samples, most significant bit first. The block clock runs at twice the master audio clock, so one master-clock period equals two block-clock cycles. A bit clock that is R master periods long therefore lasts 2R block cycles.

Software stops the outputs by dropping the divider enable, programs the settings, and raises the enable again. The settings are the divider scheme, the frame length, the two clock inversions, the data format, the sample width and the channel count. The divider has two schemes. One is a two-bit field holding the base-2 logarithm of the ratio. The other is a six-bit field holding the ratio minus one. In sixteen-bit eight-channel operation, the second scheme needs a 1.5x correction. Samples arrive on a valid/ready port. Each half of a frame carries one left-aligned sample.

Top module: `aud_ser_tx`

## Requirements
- R1: While `div_en_i` is low, or while `cfg_err_o` is high, `bclk_o` holds `bclk_inv_i` as latched, `fclk_o` holds the latched `fclk_inv_i`, and `sdata_o` is 0.
- R2: With `ext_mode_i`=0 the master-to-bit ratio R is 2 to the power `pow_sel_i` (1, 2, 4 or 8), and the bit-clock period is 2R block cycles.
- R3: With `ext_mode_i`=1 the ratio R is `xdiv_m1_i`+1, and `pow_sel_i` has no effect.
- R4: With `ext_mode_i`=1, `width_i`=16 and `chans_i`=8, the base ratio B=`xdiv_m1_i`+1 becomes R=B+B/2. If B is odd, `cfg_err_o` is 1 and no clocks run.
- R5: A `width_i` other than 16 or 32, or a `chans_i` other than 2 or 8, sets `cfg_err_o` to 1.
- R6: A frame lasts `frame_m1_i`+1 bit clocks. An internal frame level is 1 for the first half of the frame and 0 for the second half, and `fclk_o` equals that level XOR `fclk_inv_i` XOR `fmt_i2s_i`.
- R7: Each half-frame slot sends the sample's low `width_i` bits MSB first, then zeros until the slot ends. With `fmt_i2s_i`=0 the first bit lines up with the frame-level edge; with `fmt_i2s_i`=1 it comes one bit clock later. `sdata_o` changes only while the bit clock is at its inactive level.
- R8: `sample_ready_o` pulses for one block cycle at the start of each slot, and the sample presented with `sample_valid_i` in that cycle is the one the slot sends.
- R9: If `sample_valid_i` is 0 when `sample_ready_o` pulses, the slot sends zeros, and `underrun_o` pulses for one cycle in the following cycle.
- R10: Configuration inputs are latched only while `div_en_i` is low. Changes made while it is high have no effect until the next stop.
- R11: `bclk_inv_i`=1 inverts the bit clock. Data is always sampled on the rising edge of the non-inverted bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, twice the master audio clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_en_i | input | 1 | Divider enable; low stops outputs and opens configuration |
| ext_mode_i | input | 1 | 1 selects the minus-one divider scheme |
| pow_sel_i | input | 2 | Log2 of the ratio in power-of-two scheme |
| xdiv_m1_i | input | 6 | Ratio minus one in extended scheme |
| frame_m1_i | input | 12 | Bit clocks per frame minus one |
| bclk_inv_i | input | 1 | Bit-clock inversion |
| fclk_inv_i | input | 1 | Frame-clock inversion |
| fmt_i2s_i | input | 1 | 1 selects I2S (one-bit delay), 0 left-justified |
| width_i | input | 6 | Sample width, 16 or 32 |
| chans_i | input | 4 | Channel count, 2 or 8 |
| sample_i | input | 32 | Sample word, right-aligned |
| sample_valid_i | input | 1 | Sample word is valid |
| sample_ready_o | output | 1 | Slot start; sample taken this cycle |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle pulse after a slot found no sample |
| cfg_err_o | output | 1 | Latched configuration is invalid |

## Verification
The first bit clock starts one edge after the enable is seen high. The bench checks the frame-clock level at the next falling clock edge and finds the bit's rising sampling edge R block cycles later. Bit-clock and frame periods are measured in block cycles between consecutive sampling edges, so they are due at 2R and 2R times the frame length. Each slot's payload is rebuilt from the data at those sampling edges, starting at the frame-level change or one bit after it, and compared with the queue entry pushed when ready pulsed. The underrun pulse is counted one cycle after a ready pulse that found no valid sample. All outputs are read at the falling clock edge, half a cycle after the registers update.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;
    timeunit 1ns; timeprecision 1ps;

    localparam int unsigned SMP_W  = 32;
    localparam int unsigned FRM_W  = 12;
    localparam int unsigned XDIV_W = 6;
    localparam int unsigned LDIV_W = 2;
    localparam int unsigned CH_W   = 4;
    localparam int unsigned WID_W  = $clog2(SMP_W) + 1;
    localparam int unsigned RAT_W  = XDIV_W + 1;

    typedef struct packed {
        logic              ext_mode;
        logic [LDIV_W-1:0] pow_sel;
        logic [XDIV_W-1:0] xdiv_m1;
        logic [FRM_W-1:0]  frame_m1;
        logic              bclk_inv;
        logic              fclk_inv;
        logic              fmt_i2s;
        logic [WID_W-1:0]  width;
        logic [CH_W-1:0]   chans;
    } ser_cfg_t;

    localparam ser_cfg_t CFG_RST = '{
        ext_mode: 1'b0, pow_sel: '0, xdiv_m1: '0,
        frame_m1: FRM_W'(63), bclk_inv: 1'b0, fclk_inv: 1'b0,
        fmt_i2s: 1'b0, width: WID_W'(16), chans: CH_W'(2)
    };
endpackage

// File: rtl/aud_ser_ratio.sv
module aud_ser_ratio import aud_ser_pkg::*; #(
    parameter int unsigned RW = RAT_W,
    parameter int unsigned WW = WID_W
) (
    input  ser_cfg_t      cfg_i,
    output logic [RW-1:0] ratio_o,
    output logic          cfg_err_o
);
    timeunit 1ns; timeprecision 1ps;

    logic [RW-1:0] base;
    logic          widen;
    logic          fmt_ok;

    always_comb begin
        if (cfg_i.ext_mode) base = RW'(cfg_i.xdiv_m1) + RW'(1);
        else                base = RW'(1) << cfg_i.pow_sel;
        widen   = cfg_i.ext_mode && (cfg_i.width == WW'(16)) && (cfg_i.chans == CH_W'(8));
        ratio_o = widen ? base + (base >> 1) : base;
        fmt_ok  = ((cfg_i.width == WW'(16)) || (cfg_i.width == WW'(32))) &&
                  ((cfg_i.chans == CH_W'(2)) || (cfg_i.chans == CH_W'(8)));
        cfg_err_o = !fmt_ok || (widen && base[0]);
    end
endmodule

// File: rtl/aud_ser_timing.sv
module aud_ser_timing import aud_ser_pkg::*; #(
    parameter int unsigned FW = FRM_W,
    parameter int unsigned RW = RAT_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          go_i,
    input  logic [RW-1:0] ratio_i,
    input  logic [FW-1:0] frame_m1_i,
    output logic          run_o,
    output logic          phase_o,
    output logic [FW-1:0] bit_o,
    output logic          bit_start_o,
    output logic [FW-1:0] bit_next_o
);
    timeunit 1ns; timeprecision 1ps;

    typedef struct packed {
        logic          run;
        logic          phase;
        logic [RW-1:0] cnt;
        logic [FW-1:0] idx;
    } tm_t;

    tm_t  st_d, st_q;
    logic half_done;

    always_comb begin
        st_d        = st_q;
        bit_start_o = 1'b0;
        half_done   = (st_q.cnt == ratio_i - RW'(1));
        if (!go_i) begin
            st_d = '0;
        end else if (!st_q.run) begin
            st_d.run    = 1'b1;
            bit_start_o = 1'b1;
        end else if (half_done) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
            if (st_q.phase) begin
                st_d.idx    = (st_q.idx == frame_m1_i) ? '0 : st_q.idx + FW'(1);
                bit_start_o = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + RW'(1);
        end
        bit_next_o = st_d.idx;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run_o   = st_q.run;
    assign phase_o = st_q.phase;
    assign bit_o   = st_q.idx;

    assert_bit_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run && $past(st_q.run) && !$stable(st_q.idx)) |-> (!st_q.phase && $past(st_q.phase)));
endmodule

// File: rtl/aud_ser_shift.sv
module aud_ser_shift import aud_ser_pkg::*; #(
    parameter int unsigned FW = FRM_W,
    parameter int unsigned SW = SMP_W,
    parameter int unsigned WW = WID_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          go_i,
    input  logic          bit_start_i,
    input  logic [FW-1:0] bit_next_i,
    input  logic [FW-1:0] frame_m1_i,
    input  logic [FW-1:0] half_i,
    input  logic          fmt_i2s_i,
    input  logic [WW-1:0] width_i,
    input  logic [SW-1:0] sample_i,
    input  logic          valid_i,
    output logic          ready_o,
    output logic          msb_o,
    output logic          underrun_o
);
    timeunit 1ns; timeprecision 1ps;

    typedef struct packed {
        logic [SW-1:0] sh;
        logic          urun;
    } sh_t;

    sh_t           st_d, st_q;
    logic [FW-1:0] pos;
    logic [WW-1:0] lsh;
    logic [SW-1:0] aligned;
    logic          slot_start;

    always_comb begin
        pos        = (fmt_i2s_i && bit_next_i == '0) ? frame_m1_i
                                                     : bit_next_i - FW'(fmt_i2s_i);
        slot_start = bit_start_i && ((pos == '0) || (pos == half_i));
        lsh        = WW'(SW) - width_i;
        aligned    = sample_i << lsh;
        ready_o    = slot_start;
        st_d       = st_q;
        st_d.urun  = 1'b0;
        if (!go_i) begin
            st_d.sh = '0;
        end else if (slot_start) begin
            st_d.sh   = valid_i ? aligned : '0;
            st_d.urun = !valid_i;
        end else if (bit_start_i) begin
            st_d.sh = {st_q.sh[SW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign msb_o      = st_q.sh[SW-1];
    assign underrun_o = st_q.urun;

    assert_ready_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |=> !ready_o);
    assert_underrun_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        underrun_o |-> $past(ready_o && !valid_i));
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx import aud_ser_pkg::*; (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              div_en_i,
    input  logic              ext_mode_i,
    input  logic [LDIV_W-1:0] pow_sel_i,
    input  logic [XDIV_W-1:0] xdiv_m1_i,
    input  logic [FRM_W-1:0]  frame_m1_i,
    input  logic              bclk_inv_i,
    input  logic              fclk_inv_i,
    input  logic              fmt_i2s_i,
    input  logic [WID_W-1:0]  width_i,
    input  logic [CH_W-1:0]   chans_i,
    input  logic [SMP_W-1:0]  sample_i,
    input  logic              sample_valid_i,
    output logic              sample_ready_o,
    output logic              bclk_o,
    output logic              fclk_o,
    output logic              sdata_o,
    output logic              underrun_o,
    output logic              cfg_err_o
);
    timeunit 1ns; timeprecision 1ps;

    ser_cfg_t          cfg_d, cfg_q;
    logic [RAT_W-1:0]  ratio;
    logic              go;
    logic [FRM_W:0]    frames;
    logic [FRM_W-1:0]  half;
    logic              run, phase, bit_start, msb;
    logic [FRM_W-1:0]  bit_idx, bit_next;
    logic              first_half;
    logic              armed_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!div_en_i) begin
            cfg_d.ext_mode = ext_mode_i;
            cfg_d.pow_sel  = pow_sel_i;
            cfg_d.xdiv_m1  = xdiv_m1_i;
            cfg_d.frame_m1 = frame_m1_i;
            cfg_d.bclk_inv = bclk_inv_i;
            cfg_d.fclk_inv = fclk_inv_i;
            cfg_d.fmt_i2s  = fmt_i2s_i;
            cfg_d.width    = width_i;
            cfg_d.chans    = chans_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q   <= CFG_RST;
            armed_q <= 1'b0;
        end else begin
            cfg_q   <= cfg_d;
            armed_q <= 1'b1;
        end
    end

    aud_ser_ratio #(.RW(RAT_W), .WW(WID_W)) i_ratio (
        .cfg_i     (cfg_q),
        .ratio_o   (ratio),
        .cfg_err_o (cfg_err_o)
    );

    assign go     = div_en_i && !cfg_err_o;
    assign frames = {1'b0, cfg_q.frame_m1} + (FRM_W+1)'(1);
    assign half   = frames[FRM_W:1];

    aud_ser_timing #(.FW(FRM_W), .RW(RAT_W)) i_timing (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .go_i        (go),
        .ratio_i     (ratio),
        .frame_m1_i  (cfg_q.frame_m1),
        .run_o       (run),
        .phase_o     (phase),
        .bit_o       (bit_idx),
        .bit_start_o (bit_start),
        .bit_next_o  (bit_next)
    );

    aud_ser_shift #(.FW(FRM_W), .SW(SMP_W), .WW(WID_W)) i_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .go_i        (go),
        .bit_start_i (bit_start),
        .bit_next_i  (bit_next),
        .frame_m1_i  (cfg_q.frame_m1),
        .half_i      (half),
        .fmt_i2s_i   (cfg_q.fmt_i2s),
        .width_i     (cfg_q.width),
        .sample_i    (sample_i),
        .valid_i     (sample_valid_i),
        .ready_o     (sample_ready_o),
        .msb_o       (msb),
        .underrun_o  (underrun_o)
    );

    assign first_half = (bit_idx < half);
    assign bclk_o  = run ? (phase ^ cfg_q.bclk_inv) : cfg_q.bclk_inv;
    assign fclk_o  = run ? (first_half ^ cfg_q.fclk_inv ^ cfg_q.fmt_i2s) : cfg_q.fclk_inv;
    assign sdata_o = run && msb;

    assert_stop_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !div_en_i |=> (bclk_o == cfg_q.bclk_inv && fclk_o == cfg_q.fclk_inv && !sdata_o));
    assert_err_no_clock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> (!run && bclk_o == cfg_q.bclk_inv));
    assert_cfg_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(div_en_i)) |-> $stable(cfg_q));
    assert_data_inactive_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && run && $past(run) && !$stable(sdata_o)) |-> (bclk_o == cfg_q.bclk_inv));
endmodule

// File: tb/test_aud_ser_tx.sv
module test_aud_ser_tx;
    timeunit 1ns; timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, ext = 1'b0, binv = 1'b0, finv = 1'b0, i2s = 1'b0;
    logic [1:0]  pow = '0;
    logic [5:0]  xdm1 = '0;
    logic [11:0] fm1 = 12'd63;
    logic [5:0]  wid = 6'd16;
    logic [3:0]  ch = 4'd2;
    logic [31:0] sample = 32'h1234_5678;
    logic        svalid = 1'b0;
    logic        ready, bclk, fclk, sdata, urun, cerr;

    always #2.5 clk = ~clk;

    aud_ser_tx i_aud_ser_tx (
        .clk_i(clk), .rst_ni(rst_n), .div_en_i(en), .ext_mode_i(ext),
        .pow_sel_i(pow), .xdiv_m1_i(xdm1), .frame_m1_i(fm1),
        .bclk_inv_i(binv), .fclk_inv_i(finv), .fmt_i2s_i(i2s),
        .width_i(wid), .chans_i(ch), .sample_i(sample),
        .sample_valid_i(svalid), .sample_ready_o(ready), .bclk_o(bclk),
        .fclk_o(fclk), .sdata_o(sdata), .underrun_o(urun), .cfg_err_o(cerr)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected-side configuration copies for the monitor
    bit c_binv, c_finv, c_i2s;
    int c_width, exp_bper, exp_fper;
    bit drv_starve = 0;

    // scoreboard queue and driver bookkeeping
    logic [31:0] exp_q[$];
    int rdy_cnt = 0, urun_exp = 0;
    bit took = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (took) begin
                sample = sample ^ (sample << 13);
                sample = sample ^ (sample >> 17);
                sample = sample ^ (sample << 5);
                took = 0;
            end
            svalid = !drv_starve;
            if (ready) begin
                rdy_cnt++;
                if (svalid) begin
                    exp_q.push_back((c_width == 16) ? {16'h0, sample[15:0]} : sample);
                    took = 1;
                end else begin
                    exp_q.push_back(32'h0);
                    urun_exp++;
                end
            end
        end
    end

    // monitor
    bit     mon_clr = 1;
    longint cyc, last_edge, last_fr;
    bit     have_edge, have_fr, prev_b, prev_f, pend, in_slot;
    int     mpos, edges, per_err, per_n, fr_err, fr_n, slots, data_err, pad_err, urun_seen;
    longint bad_per, bad_fr;
    logic [31:0] word, bad_act, bad_exp;

    always @(negedge clk) begin
        bit braw, fraw, start_now;
        if (mon_clr) begin
            cyc = 0; have_edge = 0; have_fr = 0; prev_b = 0; prev_f = 0; pend = 0;
            in_slot = 0; mpos = 0; edges = 0; per_err = 0; per_n = 0; fr_err = 0;
            fr_n = 0; slots = 0; data_err = 0; pad_err = 0; urun_seen = 0;
            bad_per = 0; bad_fr = 0; word = 0; bad_act = 0; bad_exp = 0;
        end else begin
            cyc++;
            braw = bclk ^ c_binv;
            if (braw && !prev_b) begin
                edges++;
                if (have_edge) begin
                    per_n++;
                    if (cyc - last_edge != exp_bper) begin per_err++; bad_per = cyc - last_edge; end
                end
                last_edge = cyc; have_edge = 1;
                fraw = fclk ^ c_finv ^ c_i2s;
                if (fraw && !prev_f) begin
                    if (have_fr) begin
                        fr_n++;
                        if (cyc - last_fr != exp_fper) begin fr_err++; bad_fr = cyc - last_fr; end
                    end
                    last_fr = cyc; have_fr = 1;
                end
                start_now = 0;
                if (pend) begin pend = 0; start_now = 1; end
                if (fraw != prev_f) begin
                    if (c_i2s) pend = 1; else start_now = 1;
                end
                if (start_now) begin in_slot = 1; mpos = 0; word = 0; end
                if (in_slot) begin
                    if (mpos < c_width) begin
                        word = {word[30:0], sdata};
                        if (mpos == c_width - 1) begin
                            slots++;
                            if (exp_q.size() == 0) begin
                                data_err++; bad_act = word; bad_exp = 32'hFFFF_FFFF;
                            end else begin
                                logic [31:0] e;
                                e = exp_q.pop_front();
                                if (word != e) begin data_err++; bad_act = word; bad_exp = e; end
                            end
                        end
                    end else if (sdata) begin
                        pad_err++;
                    end
                    mpos++;
                end
                prev_f = fraw;
            end
            prev_b = braw;
            if (urun) urun_seen++;
        end
    end

    task automatic set_cfg(input bit e, input bit [1:0] p, input bit [5:0] x, input bit [11:0] f,
                           input bit bi, input bit fi, input bit s, input bit [5:0] w, input bit [3:0] c);
        @(posedge clk); #1;
        en = 0; ext = e; pow = p; xdm1 = x; fm1 = f; binv = bi; finv = fi; i2s = s; wid = w; ch = c;
        c_binv = bi; c_finv = fi; c_i2s = s; c_width = int'(w);
        repeat (2) @(posedge clk);
    endtask

    function automatic int ratio_of(input bit e, input bit [1:0] p, input bit [5:0] x,
                                    input bit [5:0] w, input bit [3:0] c);
        int b;
        if (!e) return 1 << p;
        b = int'(x) + 1;
        if (w == 16 && c == 8) return b + b / 2;
        return b;
    endfunction

    task automatic run_case(input string rdiv, input bit e, input bit [1:0] p, input bit [5:0] x,
                            input bit [11:0] f, input bit bi, input bit fi, input bit s,
                            input bit [5:0] w, input bit [3:0] c, input bit poke, input bit starve);
        int r, ncyc;
        set_cfg(e, p, x, f, bi, fi, s, w, c);
        r = ratio_of(e, p, x, w, c);
        exp_bper = 2 * r;
        exp_fper = (int'(f) + 1) * 2 * r;
        ncyc = 3 * exp_fper + 4 * exp_bper + 20;
        @(negedge clk);
        chk(cerr == 1'b0, "R5", "cfg_err on legal setting", cerr, 0);
        chk(bclk == bi && fclk == fi && sdata == 1'b0, "R1", "idle levels before enable",
            {bclk, fclk, sdata}, {bi, fi, 1'b0});
        @(posedge clk); #1;
        mon_clr = 0; exp_q.delete(); rdy_cnt = 0; urun_exp = 0; en = 1;
        @(posedge clk); @(negedge clk);
        chk(fclk == (1'b1 ^ fi ^ s) && bclk == bi, "R6", "frame level at first bit",
            fclk, 1'b1 ^ fi ^ s);
        for (int k = 0; k < ncyc; k++) begin
            @(posedge clk); #1;
            if (poke && k == ncyc / 2) begin pow = ~p; xdm1 = ~x; end
            if (starve && k == ncyc / 3) drv_starve = 1;
            if (starve && k == ncyc / 3 + exp_fper) drv_starve = 0;
        end
        en = 0;
        @(posedge clk); @(negedge clk);
        chk(bclk == bi && fclk == fi && sdata == 1'b0, "R1", "idle levels after stop",
            {bclk, fclk, sdata}, {bi, fi, 1'b0});
        repeat (2) @(negedge clk);
        chk(per_err == 0 && per_n > 4, rdiv, "bit-clock period in cycles",
            (per_err != 0) ? bad_per : longint'(per_n), (per_err != 0) ? exp_bper : 5);
        chk(fr_err == 0 && fr_n >= 2, "R6", "frame period in cycles",
            (fr_err != 0) ? bad_fr : longint'(fr_n), (fr_err != 0) ? exp_fper : 2);
        chk(data_err == 0 && slots >= 4, "R7", "slot payload MSB first",
            (data_err != 0) ? longint'(bad_act) : longint'(slots),
            (data_err != 0) ? longint'(bad_exp) : 4);
        chk(pad_err == 0, "R7", "zero padding after sample bits", pad_err, 0);
        chk(rdy_cnt >= slots && rdy_cnt <= slots + 2, "R8", "ready pulses per slot", rdy_cnt, slots);
        chk(urun_seen == urun_exp, "R9", "underrun pulses", urun_seen, urun_exp);
        if (starve) chk(urun_exp >= 2, "R9", "starved slots sent as zeros", urun_exp, 2);
        @(posedge clk); #1;
        mon_clr = 1;
        pow = p; xdm1 = x;
    endtask

    task automatic err_case(input string req, input bit e, input bit [5:0] x,
                            input bit [5:0] w, input bit [3:0] c);
        set_cfg(e, 2'd1, x, 12'd63, 1'b1, 1'b0, 1'b0, w, c);
        @(negedge clk);
        chk(cerr == 1'b1, req, "cfg_err on illegal setting", cerr, 1);
        @(posedge clk); #1;
        mon_clr = 0; en = 1;
        repeat (120) @(posedge clk);
        @(negedge clk);
        chk(edges == 0 && bclk == 1'b1 && fclk == 1'b0 && sdata == 1'b0, "R1",
            "no clocks while config invalid", edges, 0);
        @(posedge clk); #1;
        en = 0; mon_clr = 1;
    endtask

    initial begin
        c_binv = 0; c_finv = 0; c_i2s = 0; c_width = 16; exp_bper = 2; exp_fper = 128;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(bclk == 0 && fclk == 0 && sdata == 0 && ready == 0 && urun == 0 && cerr == 0,
            "R1", "reset state", {bclk, fclk, sdata, ready, urun, cerr}, 0);
        // R2: power-of-two ratio 2, left-justified, 16-bit stereo
        run_case("R2", 0, 2'd1, 6'd0, 12'd63, 0, 0, 0, 6'd16, 4'd2, 0, 0);
        // R11 and R6: ratio 1, I2S, 32-bit, both clocks inverted
        run_case("R11", 0, 2'd0, 6'd0, 12'd63, 1, 1, 1, 6'd32, 4'd2, 0, 0);
        // R4: extended base 4 in 16-bit eight-channel mode gives ratio 6; legacy field ignored
        run_case("R4", 1, 2'd2, 6'd3, 12'd63, 0, 0, 0, 6'd16, 4'd8, 0, 0);
        // R3: extended base 3, 32-bit eight-channel, legacy field 3 has no effect
        run_case("R3", 1, 2'd3, 6'd2, 12'd63, 0, 1, 1, 6'd32, 4'd8, 0, 0);
        // R4: odd base in 16-bit eight-channel mode is rejected
        err_case("R4", 1, 6'd2, 6'd16, 4'd8);
        // R5: illegal width, then illegal channel count
        err_case("R5", 0, 6'd0, 6'd24, 4'd2);
        err_case("R5", 0, 6'd0, 6'd16, 4'd4);
        // R9: 32-bit frame with a starved window
        run_case("R2", 0, 2'd2, 6'd0, 12'd31, 0, 0, 1, 6'd16, 4'd2, 0, 1);
        // R10: divider inputs changed while enabled must not change the period
        run_case("R10", 0, 2'd1, 6'd0, 12'd63, 0, 0, 0, 6'd16, 4'd2, 1, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule